// File: doc/BRIEF.md
# Text-Mode Character Pixel Serializer

This block converts a stream of text-mode character cells into a serial stream of pixel bits, one bit per dot. For each cell, upstream fetch logic supplies a character code and the 8-bit glyph row for the current scan line. The block shifts the glyph out leftmost pixel first. When the cell is nine dots wide, it appends a ninth dot. That dot repeats the last glyph pixel for the line-graphics code range, so box-drawing characters join up across cells, and it is background for every other code.

A single control register sits on a small write/read bus and holds three options: the cell width (8 or 9 dots), halving of the dot rate relative to the incoming pixel clock, and a screen blank. Horizontal and vertical sync come from an external timing generator. They pass through the same number of register stages as the pixels, so the two streams stay aligned.

Upstream fetch logic runs off the `cell_req` output. While `cell_req` is high, the block samples `char_code` and `glyph_row` on the next rising clock edge, and that cell starts on the following dot.

Top module: `txt_pix_serializer`

## Requirements
- R1: After reset, the control register reads 02h (9-dot cells, full dot rate, screen visible) and `pix_out`, `hsync_out` and `vsync_out` are 0.
- R2: Register writes land only when `reg_addr` equals `CTRL_ADDR`, and only bits 0 (narrow), 3 (halve) and 5 (blank) are stored. Bit 1 always reads 1 and bits 7:6, 4 and 2 read 0. A read at any other address returns 00h, and a write to any other address leaves the register unchanged.
- R3: Bit 0 selects the cell width: 1 gives 8 dots per cell and 0 gives 9 dots per cell.
- R4: Glyph bits go out most significant bit first. Bit 7 is the first (leftmost) dot of the cell and bit 0 is the eighth dot.
- R5: In 9-dot cells whose code is C0h to DFh inclusive, the ninth dot equals glyph bit 0.
- R6: In 9-dot cells with any other code, the ninth dot is 0.
- R7: `cell_req` is high for one dot-enabled clock at the last dot of each cell. Code and glyph are captured on that clock edge, and the cell they belong to starts on the next dot. Consecutive requests are one cell span apart, where the span is the dot count times the clocks per dot.
- R8: A width written in the middle of a cell takes effect only from the next cell. The cell in progress keeps the width it started with.
- R9: When bit 3 is 1, every dot lasts two pixel clocks and the dot counter advances only on dot-enable clocks. When bit 3 is 0, every clock is a dot.
- R10: When bit 5 is 1, all pixels are 0 while the sync outputs keep following their inputs.
- R11: A pixel and the sync inputs present in the same cycle appear at the outputs together, `PIX_DLY` clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Incoming pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| char_code | input | 8 | Character code of the next cell |
| glyph_row | input | 8 | Glyph row of the next cell |
| cell_req | output | 1 | Next cell is taken at this clock edge |
| hsync_in | input | 1 | Horizontal sync from the timing generator |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| pix_out | output | 1 | Serial pixel (1 = foreground) |
| hsync_out | output | 1 | Delayed horizontal sync |
| vsync_out | output | 1 | Delayed vertical sync |

## Verification
The bench builds the block with `PIX_DLY` = 2, `ADDR_W` = 3 and `CTRL_ADDR` = 2. With two output stages, a pipeline that moved pixels and sync by different amounts would show up as misalignment, which a single stage would hide. Putting the register at a nonzero address in a wider space exercises the address decode, including writes and reads to other addresses. Under these settings the bench tracks every cell span, every dot, and the hand-off of width and dot-rate changes at cell boundaries against its own pixel schedule.

// File: rtl/txs_pkg.sv
package txs_pkg;

  localparam int unsigned GLYPH_BITS = 8;
  localparam int unsigned IDX_W      = 4;

  localparam int unsigned BIT_NARROW = 0;
  localparam int unsigned BIT_FIXED1 = 1;
  localparam int unsigned BIT_HALVE  = 3;
  localparam int unsigned BIT_BLANK  = 5;

  typedef logic [IDX_W-1:0] dot_idx_t;

  typedef struct packed {
    logic blank;
    logic halve;
    logic narrow;
  } ctrl_t;

  // Line-graphics range C0h..DFh: top three bits are 110.
  function automatic logic is_line_gfx(input logic [7:0] code);
    return code[7:5] == 3'b110;
  endfunction

  // Index of the final dot of a cell.
  function automatic dot_idx_t last_dot(input logic narrow);
    return narrow ? dot_idx_t'(GLYPH_BITS - 1) : dot_idx_t'(GLYPH_BITS);
  endfunction

  // Pixel value for one dot position of a cell.
  function automatic logic dot_pixel(input logic [7:0] glyph,
                                     input logic [7:0] code,
                                     input dot_idx_t   idx);
    if (idx < dot_idx_t'(GLYPH_BITS)) return glyph[~idx[2:0]];
    return is_line_gfx(code) ? glyph[0] : 1'b0;
  endfunction

  // Read view of the control register with fixed bits applied.
  function automatic logic [7:0] ctrl_read(input ctrl_t c);
    logic [7:0] r;
    r             = '0;
    r[BIT_NARROW] = c.narrow;
    r[BIT_FIXED1] = 1'b1;
    r[BIT_HALVE]  = c.halve;
    r[BIT_BLANK]  = c.blank;
    return r;
  endfunction

endpackage

// File: rtl/txs_ctrl_reg.sv
module txs_ctrl_reg
  import txs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output ctrl_t             ctrl,
  output logic [7:0]        reg_rdata
);

  logic addr_hit;
  assign addr_hit = (reg_addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (reg_we && addr_hit) begin
      ctrl.narrow <= reg_wdata[BIT_NARROW];
      ctrl.halve  <= reg_wdata[BIT_HALVE];
      ctrl.blank  <= reg_wdata[BIT_BLANK];
    end
  end

  assign reg_rdata = addr_hit ? ctrl_read(ctrl) : 8'h00;

  // R2
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && addr_hit) |=> (ctrl.halve == $past(reg_wdata[BIT_HALVE])) &&
                             (ctrl.narrow == $past(reg_wdata[BIT_NARROW])));

  // R2
  wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !addr_hit) |=> $stable(ctrl));

endmodule

// File: rtl/txs_dot_timer.sv
module txs_dot_timer
  import txs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     halve,
  input  logic     narrow,
  output logic     dot_en,
  output dot_idx_t dot_idx,
  output logic     cell_load
);

  logic     phase_q;
  dot_idx_t idx_q;
  logic     narrow_q;   // width of the cell in progress

  assign dot_en    = !halve || phase_q;
  assign cell_load = dot_en && (idx_q == last_dot(narrow_q));
  assign dot_idx   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      idx_q    <= last_dot(1'b0);
      narrow_q <= 1'b0;
    end else begin
      phase_q <= halve ? !phase_q : 1'b0;
      if (cell_load) begin
        idx_q    <= '0;
        narrow_q <= narrow;
      end else if (dot_en) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R3
  dot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= last_dot(narrow_q));

  // R7
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_load |=> (idx_q == '0));

  // R9
  halve_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halve && !dot_en) |=> dot_en);

  // R8
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_load |=> $stable(narrow_q));

endmodule

// File: rtl/txs_pixel_path.sv
module txs_pixel_path
  import txs_pkg::*;
#(
  parameter int unsigned PIX_DLY = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_load,
  input  logic [7:0] char_code,
  input  logic [7:0] glyph_row,
  input  dot_idx_t   dot_idx,
  input  logic       blank,
  input  logic       hsync_in,
  input  logic       vsync_in,
  output logic       pix_out,
  output logic       hsync_out,
  output logic       vsync_out
);

  logic [7:0] code_q;
  logic [7:0] glyph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      glyph_q <= '0;
    end else if (cell_load) begin
      code_q  <= char_code;
      glyph_q <= glyph_row;
    end
  end

  logic pix_now;
  assign pix_now = !blank && dot_pixel(glyph_q, code_q, dot_idx);

  logic [PIX_DLY-1:0] pix_pipe;
  logic [PIX_DLY-1:0] hs_pipe;
  logic [PIX_DLY-1:0] vs_pipe;

  generate
    if (PIX_DLY == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pix_pipe <= '0;
          hs_pipe  <= '0;
          vs_pipe  <= '0;
        end else begin
          pix_pipe <= pix_now;
          hs_pipe  <= hsync_in;
          vs_pipe  <= vsync_in;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pix_pipe <= '0;
          hs_pipe  <= '0;
          vs_pipe  <= '0;
        end else begin
          pix_pipe <= {pix_pipe[PIX_DLY-2:0], pix_now};
          hs_pipe  <= {hs_pipe[PIX_DLY-2:0], hsync_in};
          vs_pipe  <= {vs_pipe[PIX_DLY-2:0], vsync_in};
        end
      end
    end
  endgenerate

  assign pix_out   = pix_pipe[PIX_DLY-1];
  assign hsync_out = hs_pipe[PIX_DLY-1];
  assign vsync_out = vs_pipe[PIX_DLY-1];

  // R10
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> !pix_pipe[0]);

  // R6
  ninth_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dot_idx == dot_idx_t'(GLYPH_BITS)) && !is_line_gfx(code_q)) |=> !pix_pipe[0]);

  // R11
  sync_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hs_pipe[0] == $past(hsync_in)) && (vs_pipe[0] == $past(vsync_in)));

endmodule

// File: rtl/txt_pix_serializer.sv
module txt_pix_serializer
  import txs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned PIX_DLY   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output logic [7:0]        reg_rdata,
  input  logic [7:0]        char_code,
  input  logic [7:0]        glyph_row,
  output logic              cell_req,
  input  logic              hsync_in,
  input  logic              vsync_in,
  output logic              pix_out,
  output logic              hsync_out,
  output logic              vsync_out
);

  ctrl_t    ctrl;
  logic     dot_en;
  dot_idx_t dot_idx;
  logic     cell_load;

  txs_ctrl_reg #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .ctrl      (ctrl),
    .reg_rdata (reg_rdata)
  );

  txs_dot_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .halve     (ctrl.halve),
    .narrow    (ctrl.narrow),
    .dot_en    (dot_en),
    .dot_idx   (dot_idx),
    .cell_load (cell_load)
  );

  txs_pixel_path #(
    .PIX_DLY (PIX_DLY)
  ) u_pix (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_load (cell_load),
    .char_code (char_code),
    .glyph_row (glyph_row),
    .dot_idx   (dot_idx),
    .blank     (ctrl.blank),
    .hsync_in  (hsync_in),
    .vsync_in  (vsync_in),
    .pix_out   (pix_out),
    .hsync_out (hsync_out),
    .vsync_out (vsync_out)
  );

  assign cell_req = cell_load;

  // R7
  req_on_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_req |-> dot_en);

endmodule

// File: tb/tb_txt_pix_serializer.sv
module tb_txt_pix_serializer;

  localparam int ADDR_W    = 3;
  localparam int CTRL_ADDR = 2;
  localparam int PIX_DLY   = 2;
  localparam int HIST      = 512;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] reg_addr = ADDR_W'(CTRL_ADDR);
  logic [7:0]        reg_wdata = '0;
  logic              reg_we = 1'b0;
  logic [7:0]        reg_rdata;
  logic [7:0]        char_code = '0;
  logic [7:0]        glyph_row = '0;
  logic              cell_req;
  logic              hsync_in = 1'b0;
  logic              vsync_in = 1'b0;
  logic              pix_out;
  logic              hsync_out;
  logic              vsync_out;

  txt_pix_serializer #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .PIX_DLY   (PIX_DLY)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .char_code (char_code),
    .glyph_row (glyph_row),
    .cell_req  (cell_req),
    .hsync_in  (hsync_in),
    .vsync_in  (vsync_in),
    .pix_out   (pix_out),
    .hsync_out (hsync_out),
    .vsync_out (vsync_out)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Bench restatement of the dot rules.
  function automatic logic ref_dot(input logic [7:0] code, input logic [7:0] g, input int d);
    if (d < 8) return g[7-d];
    if (code >= 8'hC0 && code <= 8'hDF) return g[0];
    return 1'b0;
  endfunction

  // Shadow of the control register.
  logic sh_narrow = 1'b0, sh_halve = 1'b0, sh_blank = 1'b0;

  // Pixel schedule and sync history.
  logic  exp_v [HIST];
  logic  exp_p [HIST];
  string exp_tag [HIST];
  logic  hs_hist [HIST];
  logic  vs_hist [HIST];

  // Cell source.
  logic [7:0] cell_code [8];
  logic [7:0] cell_glyph [8];
  int    n_cells = 1;
  int    ptr = 0;
  string cur_tag = "R4";
  bit    run = 1'b0;
  int    sync_from = -1;
  bit    last_req_valid = 1'b0;
  int    last_req = 0;
  int    last_span = 0;

  initial begin
    for (int i = 0; i < HIST; i++) begin
      exp_v[i] = 1'b0; exp_p[i] = 1'b0; exp_tag[i] = "";
      hs_hist[i] = 1'b0; vs_hist[i] = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin cell_code[i] = '0; cell_glyph[i] = '0; end
  end

  task automatic clear_sched();
    for (int i = 0; i < HIST; i++) exp_v[i] = 1'b0;
  endtask

  // Feed, schedule and compare, all away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && run) begin
      if (exp_v[cyc % HIST]) begin
        chk(pix_out == exp_p[cyc % HIST], exp_tag[cyc % HIST], pix_out, exp_p[cyc % HIST]);
        exp_v[cyc % HIST] = 1'b0;
      end
      if (sync_from >= 0 && cyc >= sync_from) begin
        chk(hsync_out == hs_hist[(cyc-PIX_DLY) % HIST], "R11 hsync", hsync_out, hs_hist[(cyc-PIX_DLY) % HIST]);
        chk(vsync_out == vs_hist[(cyc-PIX_DLY) % HIST], "R11 vsync", vsync_out, vs_hist[(cyc-PIX_DLY) % HIST]);
      end
      if (sync_from < 0) sync_from = cyc + PIX_DLY;
      hsync_in = cyc[2] ^ cyc[4];
      vsync_in = cyc[5];
      hs_hist[cyc % HIST] = hsync_in;
      vs_hist[cyc % HIST] = vsync_in;
      if (cell_req) begin
        automatic int w = sh_narrow ? 8 : 9;
        automatic int h = sh_halve ? 2 : 1;
        automatic logic [7:0] c = cell_code[ptr % n_cells];
        automatic logic [7:0] g = cell_glyph[ptr % n_cells];
        ptr++;
        char_code = c;
        glyph_row = g;
        for (int j = 0; j < w*h; j++) begin
          automatic int k = (cyc + 1 + j + PIX_DLY) % HIST;
          exp_v[k]   = 1'b1;
          exp_p[k]   = sh_blank ? 1'b0 : ref_dot(c, g, j / h);
          exp_tag[k] = cur_tag;
        end
        if (last_req_valid)
          chk(cyc - last_req == last_span, {cur_tag, " R7 span"}, cyc - last_req, last_span);
        last_req_valid = 1'b1;
        last_req  = cyc;
        last_span = w * h;
      end
    end
  end

  task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
    if (a == ADDR_W'(CTRL_ADDR)) begin
      if (sh_halve != d[3]) begin clear_sched(); last_req_valid = 1'b0; end
      if (sh_blank != d[5]) clear_sched();
      sh_narrow = d[0]; sh_halve = d[3]; sh_blank = d[5];
    end
    reg_addr = ADDR_W'(CTRL_ADDR);
  endtask

  task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = ADDR_W'(CTRL_ADDR);
  endtask

  task automatic set_cells(input int n, input logic [63:0] codes, input logic [63:0] glyphs);
    n_cells = n;
    for (int i = 0; i < n; i++) begin
      cell_code[i]  = codes[8*i +: 8];
      cell_glyph[i] = glyphs[8*i +: 8];
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(reg_rdata == 8'h02, "R1 reg reset", reg_rdata, 8'h02);
    chk(pix_out == 1'b0, "R1 pix reset", pix_out, 0);
    chk(hsync_out == 1'b0 && vsync_out == 1'b0, "R1 sync reset", {hsync_out, vsync_out}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    reg_write(ADDR_W'(CTRL_ADDR), 8'hFF);
    reg_read(ADDR_W'(CTRL_ADDR), d);
    chk(d == 8'h2B, "R2 all ones", d, 8'h2B);
    reg_write(ADDR_W'(CTRL_ADDR), 8'h00);
    reg_read(ADDR_W'(CTRL_ADDR), d);
    chk(d == 8'h02, "R2 all zeros", d, 8'h02);
    reg_read(ADDR_W'(5), d);
    chk(d == 8'h00, "R2 other addr read", d, 8'h00);
    reg_write(ADDR_W'(5), 8'hFF);
    reg_read(ADDR_W'(CTRL_ADDR), d);
    chk(d == 8'h02, "R2 other addr write ignored", d, 8'h02);
    reg_write(ADDR_W'(CTRL_ADDR), 8'h21);
    reg_read(ADDR_W'(CTRL_ADDR), d);
    chk(d == 8'h23, "R2 blank+narrow", d, 8'h23);
    reg_write(ADDR_W'(CTRL_ADDR), 8'h00);
  endtask

  task automatic t_msb();
    cur_tag = "R4";
    set_cells(3, {40'h0, 8'h41, 8'h41, 8'h41}, {40'h0, 8'hA5, 8'h01, 8'h80});
    run = 1'b1;
    repeat (70) @(posedge clk);
  endtask

  task automatic t_ninth();
    cur_tag = "R5 R6";
    set_cells(6, {16'h0, 8'hE0, 8'hBF, 8'hDF, 8'hC5, 8'hC0, 8'h20},
                 {16'h0, 8'hFF, 8'hFF, 8'h01, 8'h00, 8'h01, 8'h01});
    repeat (120) @(posedge clk);
  endtask

  task automatic t_narrow();
    cur_tag = "R3";
    reg_write(ADDR_W'(CTRL_ADDR), 8'h01);
    set_cells(3, {40'h0, 8'hC0, 8'hDF, 8'h10}, {40'h0, 8'h3C, 8'hFF, 8'h81});
    repeat (80) @(posedge clk);
  endtask

  task automatic t_boundary();
    cur_tag = "R8";
    set_cells(2, {48'h0, 8'hC3, 8'hC0}, {48'h0, 8'h81, 8'h01});
    @(negedge clk);
    while (!cell_req) @(negedge clk);
    repeat (2) @(negedge clk);
    reg_write(ADDR_W'(CTRL_ADDR), 8'h00);
    repeat (60) @(posedge clk);
    @(negedge clk);
    while (!cell_req) @(negedge clk);
    repeat (3) @(negedge clk);
    reg_write(ADDR_W'(CTRL_ADDR), 8'h01);
    repeat (40) @(posedge clk);
    reg_write(ADDR_W'(CTRL_ADDR), 8'h00);
    repeat (20) @(posedge clk);
  endtask

  task automatic t_halve();
    cur_tag = "R9";
    set_cells(3, {40'h0, 8'hC1, 8'h55, 8'h30}, {40'h0, 8'h01, 8'hAA, 8'hC3});
    reg_write(ADDR_W'(CTRL_ADDR), 8'h08);
    repeat (110) @(posedge clk);
    reg_write(ADDR_W'(CTRL_ADDR), 8'h09);
    repeat (70) @(posedge clk);
    reg_write(ADDR_W'(CTRL_ADDR), 8'h00);
    repeat (40) @(posedge clk);
  endtask

  task automatic t_blank();
    cur_tag = "R10";
    set_cells(2, {48'h0, 8'hC0, 8'h41}, {48'h0, 8'hFF, 8'hFF});
    reg_write(ADDR_W'(CTRL_ADDR), 8'h20);
    repeat (60) @(posedge clk);
    cur_tag = "R10 restore";
    reg_write(ADDR_W'(CTRL_ADDR), 8'h00);
    repeat (40) @(posedge clk);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_msb();
    t_ninth();
    t_narrow();
    t_boundary();
    t_halve();
    t_blank();
    repeat (5) @(posedge clk);
    finish_sim();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_sim();
  end

endmodule